// File: doc/BRIEF.md
# Register-Programmed CRC32 Accelerator

This block computes a 32-bit CRC over a stream of 32-bit words that a host writes through a simple register port. The host sets a generator polynomial, seeds the running value, sets how many words to process and then enables the block. Each word it then writes to the data port goes into a small input queue. While the block is running and the polynomial is ready, one word per clock leaves the queue and is folded into the running value, most significant bit first.

A word counter counts down as words are consumed. When it runs out, the block sets a count-expired flag and reloads the counter from a reload register. At that point it also compares the final CRC with a compare register and flags any mismatch. Both flags can drive an interrupt through a mask that has separate set and clear addresses. Independent reordering controls reshape the input word (bits within bytes, byte order, 16-bit halves) and fully bit-reverse the polynomial, the visible result and the compare value. A further control chooses whether the input reordering is applied as a word enters the queue or as it leaves.

Top module: `crc_engine`

## Requirements
- R1: After reset the control (address 0), word count (address 1), interrupt mask (address 5) and result (address 10) all read 0. Status (address 9) reads 0x00090000, which is input-ready bit 16 and polynomial-ready bit 19 set, queue level 0 and both flags clear. irq is low.
- R2: A write to address 11 seeds the running CRC. Each consumed word d updates it with 32 serial steps taken from d[31] down to d[0]: feedback = crc[31] xor d[i], crc shifts left by one, and the effective polynomial is XORed in when feedback is 1. Address 10 returns the running value.
- R3: Writing the polynomial (address 8) clears status bit 19 for PREP_CYCLES (8) clocks. No word is consumed while that bit is clear.
- R4: A word is consumed only when control bit 0 (enable) is 1, control bits 7:4 hold mode 3, status bit 19 is 1, the queue is not empty and the count (address 1) is nonzero. Each consumed word lowers the count by one. Consuming the word that takes the count from 1 sets status bit 4 and loads the count from the reload register (address 2).
- R5: When status bit 4 is set, status bit 1 is set as well if the CRC after that word differs from the effective compare value. The compare register is at address 3.
- R6: Writing 1 to status bit 1 or bit 4 at address 9 clears that bit. Writing 0 leaves it unchanged.
- R7: Writing 1s to address 6 sets mask bits 1 and 4, and writing 1s to address 7 clears them. irq = (status[1] and mask[1]) or (status[4] and mask[4]).
- R8: Writes to the data port (address 4) are ignored while enable is 0 or the queue is full (FIFO_DEPTH = 4 words). Status bits 22:20 report the queue level, and bit 16 is 1 while the queue is not full.
- R9: Control bits 16, 17 and 18 reshape the input word, applied in this order: reverse the bits within each byte, reverse the byte order, swap the 16-bit halves.
- R10: With control bit 19 set, the input reshaping uses the controls in force when the word is written. With bit 19 clear, it uses the controls in force when the word is consumed.
- R11: Control bits 20, 21 and 22 fully bit-reverse the value read at address 10, the polynomial used in the update and the compare value, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W (4) | Register read word address |
| rd_data | output | 32 | Combinational read data for rd_addr |
| irq | output | 1 | Masked OR of the two status flags |

## Verification
The CRC update is run against six stimulus rows that vary the seed (all-zero, all-one and mixed), three different polynomials, and every input, polynomial, result and compare reshaping control, both alone and combined. These rows separate errors in shift direction, feedback tap, reshaping order and reversal placement. Each row also switches between a matching and a deliberately wrong compare value, so a stuck or inverted mismatch flag shows up. Directed sequences keep words in the queue by holding the count at zero, a wrong mode or a pending polynomial. This exposes the queue level and the full-queue drop, and lets reshaping controls change between the write and the consume, which separates the two timing choices. A reload of 2 shows that counting carries on after expiry.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

   // word addresses of the register port
   localparam int A_CTRL    = 0;
   localparam int A_COUNT   = 1;
   localparam int A_RELOAD  = 2;
   localparam int A_CMP     = 3;
   localparam int A_DATA    = 4;
   localparam int A_IEN     = 5;
   localparam int A_IEN_SET = 6;
   localparam int A_IEN_CLR = 7;
   localparam int A_POLY    = 8;
   localparam int A_STAT    = 9;
   localparam int A_RESULT  = 10;
   localparam int A_SEED    = 11;

   localparam logic [3:0] MODE_CRC = 4'd3;

   function automatic logic [31:0] rev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   // bit-in-byte reverse, then byte reverse, then half swap
   function automatic logic [31:0] shape_word(input logic [31:0] v,
                                              input logic bit_rev,
                                              input logic byte_rev,
                                              input logic half_swap);
      logic [31:0] a;
      logic [31:0] b;
      for (int k = 0; k < 4; k++)
         for (int i = 0; i < 8; i++)
            a[8*k+i] = bit_rev ? v[8*k+7-i] : v[8*k+i];
      b = byte_rev ? {a[7:0], a[15:8], a[23:16], a[31:24]} : a;
      return half_swap ? {b[15:0], b[31:16]} : b;
   endfunction

   // one 32-bit word folded in MSB first
   function automatic logic [31:0] fold_word(input logic [31:0] c_in,
                                             input logic [31:0] d,
                                             input logic [31:0] p);
      logic [31:0] c;
      logic fb;
      c = c_in;
      for (int i = 31; i >= 0; i--) begin
         fb = c[31] ^ d[i];
         c  = {c[30:0], 1'b0} ^ (fb ? p : 32'h0);
      end
      return c;
   endfunction

endpackage

// File: rtl/crc_word_fifo.sv
module crc_word_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [W-1:0]                   din,
   input  logic                           pop,
   output logic [W-1:0]                   dout,
   output logic [$clog2(DEPTH+1)-1:0]     level,
   output logic                           full,
   output logic                           empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("crc_word_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [LVL_W-1:0] lvl_q;
   logic             do_push, do_pop;

   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem_q[rp_q];
   assign level   = lvl_q;

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   // R8
   level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= LVL_W'(DEPTH));

endmodule

// File: rtl/crc_prep_timer.sv
module crc_prep_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   initial begin
      assert (CYCLES >= 0) else $error("crc_prep_timer: CYCLES must be >= 0");
   end

   generate
      if (CYCLES == 0) begin : g_instant
         assign done = 1'b1;
      end else begin : g_count
         localparam int TW = $clog2(CYCLES + 1);
         logic [TW-1:0] t_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          t_q <= '0;
            else if (start)      t_q <= TW'(CYCLES);
            else if (t_q != '0)  t_q <= t_q - 1'b1;
         end
         assign done = (t_q == '0);

         // R3
         prep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> !done);
      end
   endgenerate

endmodule

// File: rtl/crc_accum.sv
module crc_accum
   import crc_eng_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] load_val,
   input  logic        step,
   input  logic [31:0] word,
   input  logic [31:0] poly,
   output logic [31:0] crc_q,
   output logic [31:0] crc_next
);
   assign crc_next = fold_word(crc_q, word, poly);

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= '0;
      else if (load)  crc_q <= load_val;
      else if (step)  crc_q <= crc_next;
   end

   // R2
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (crc_q == $past(load_val)));

endmodule

// File: rtl/crc_engine.sv
module crc_engine
   import crc_eng_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int FIFO_DEPTH  = 4,
   parameter int PREP_CYCLES = 8,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              irq
);
   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

   initial begin
      assert (ADDR_W >= 4) else $error("crc_engine: ADDR_W too small");
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("crc_engine: CNT_W out of range");
      assert (LVL_W <= 3) else $error("crc_engine: level does not fit status field");
   end

   // programmed state
   logic             en_q;
   logic [3:0]       mode_q;
   logic [6:0]       mir_q;   // [0]bit [1]byte [2]half [3]store [4]res [5]poly [6]cmp
   logic [CNT_W-1:0] cnt_q, rld_q;
   logic [31:0]      cmp_q, poly_q;
   logic             ien_err_q, ien_exp_q, st_err_q, st_exp_q;

   // write decode
   logic ctl_we, cnt_we, rld_we, cmp_we, dat_we, set_we, clr_we, poly_we, st_we, seed_we;
   assign ctl_we  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign cnt_we  = wr_en && (wr_addr == ADDR_W'(A_COUNT));
   assign rld_we  = wr_en && (wr_addr == ADDR_W'(A_RELOAD));
   assign cmp_we  = wr_en && (wr_addr == ADDR_W'(A_CMP));
   assign dat_we  = wr_en && (wr_addr == ADDR_W'(A_DATA));
   assign set_we  = wr_en && (wr_addr == ADDR_W'(A_IEN_SET));
   assign clr_we  = wr_en && (wr_addr == ADDR_W'(A_IEN_CLR));
   assign poly_we = wr_en && (wr_addr == ADDR_W'(A_POLY));
   assign st_we   = wr_en && (wr_addr == ADDR_W'(A_STAT));
   assign seed_we = wr_en && (wr_addr == ADDR_W'(A_SEED));

   // input queue with reshaping on either side
   logic [31:0]      q_din, q_dout, word;
   logic [LVL_W-1:0] q_level;
   logic             q_full, q_empty, consume, tbl_done;

   assign q_din = mir_q[3] ? shape_word(wr_data, mir_q[0], mir_q[1], mir_q[2]) : wr_data;
   assign word  = mir_q[3] ? q_dout : shape_word(q_dout, mir_q[0], mir_q[1], mir_q[2]);

   crc_word_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(dat_we && en_q), .din(q_din),
      .pop(consume), .dout(q_dout),
      .level(q_level), .full(q_full), .empty(q_empty)
   );

   crc_prep_timer #(.CYCLES(PREP_CYCLES)) u_prep (
      .clk(clk), .rst_n(rst_n), .start(poly_we), .done(tbl_done)
   );

   logic [31:0] poly_eff, cmp_eff, crc_q, crc_next;
   logic        last;
   assign poly_eff = mir_q[5] ? rev32(poly_q) : poly_q;
   assign cmp_eff  = mir_q[6] ? rev32(cmp_q)  : cmp_q;
   assign consume  = !q_empty && en_q && (mode_q == MODE_CRC) && tbl_done && (cnt_q != '0);
   assign last     = consume && (cnt_q == CNT_W'(1));

   crc_accum u_acc (
      .clk(clk), .rst_n(rst_n),
      .load(seed_we), .load_val(wr_data),
      .step(consume), .word(word), .poly(poly_eff),
      .crc_q(crc_q), .crc_next(crc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         mode_q    <= '0;
         mir_q     <= '0;
         cnt_q     <= '0;
         rld_q     <= '0;
         cmp_q     <= '0;
         poly_q    <= '0;
         ien_err_q <= 1'b0;
         ien_exp_q <= 1'b0;
         st_err_q  <= 1'b0;
         st_exp_q  <= 1'b0;
      end else begin
         if (ctl_we) begin
            en_q   <= wr_data[0];
            mode_q <= wr_data[7:4];
            mir_q  <= wr_data[22:16];
         end
         if (cnt_we)       cnt_q <= wr_data[CNT_W-1:0];
         else if (consume) cnt_q <= last ? rld_q : cnt_q - 1'b1;
         if (rld_we)  rld_q  <= wr_data[CNT_W-1:0];
         if (cmp_we)  cmp_q  <= wr_data;
         if (poly_we) poly_q <= wr_data;
         if (set_we) begin
            ien_err_q <= ien_err_q | wr_data[1];
            ien_exp_q <= ien_exp_q | wr_data[4];
         end
         if (clr_we) begin
            ien_err_q <= ien_err_q & ~wr_data[1];
            ien_exp_q <= ien_exp_q & ~wr_data[4];
         end
         st_exp_q <= (st_exp_q && !(st_we && wr_data[4])) || last;
         st_err_q <= (st_err_q && !(st_we && wr_data[1])) || (last && (crc_next != cmp_eff));
      end
   end

   assign irq = (st_exp_q && ien_exp_q) || (st_err_q && ien_err_q);

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_CTRL):   rd_data = {9'b0, mir_q, 8'b0, mode_q, 3'b0, en_q};
         ADDR_W'(A_COUNT):  rd_data = 32'(cnt_q);
         ADDR_W'(A_RELOAD): rd_data = 32'(rld_q);
         ADDR_W'(A_CMP):    rd_data = cmp_q;
         ADDR_W'(A_IEN):    rd_data = {27'b0, ien_exp_q, 2'b0, ien_err_q, 1'b0};
         ADDR_W'(A_POLY):   rd_data = poly_q;
         ADDR_W'(A_STAT):   rd_data = {9'b0, 3'(q_level), tbl_done, 2'b0, !q_full,
                                       11'b0, st_exp_q, 2'b0, st_err_q, 1'b0};
         ADDR_W'(A_RESULT): rd_data = mir_q[4] ? rev32(crc_q) : crc_q;
         ADDR_W'(A_SEED):   rd_data = crc_q;
         default:           rd_data = '0;
      endcase
   end

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!consume && !cnt_we) |=> $stable(cnt_q));

   // R4
   cnt_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && cnt_q == CNT_W'(1)) |=> st_exp_q);

   // R7
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_exp_q && ien_exp_q) |-> irq);

   // R8
   write_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !en_q) |=> $stable(q_level));

endmodule

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int n_cmp = 0;
   int n_mis = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   crc_engine dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   localparam logic [31:0] RUN = 32'h31;   // enable + mode 3

   typedef struct packed {
      logic [31:0] seed;
      logic [31:0] poly;
      logic [6:0]  mir;
      logic [31:0] d0;
      logic [31:0] d1;
      logic [31:0] d2;
      logic        match;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{32'h00000000, 32'h04C11DB7, 7'h00, 32'h12345678, 32'hDEADBEEF, 32'h00000000, 1'b1},
      '{32'hFFFFFFFF, 32'h04C11DB7, 7'h09, 32'h00000001, 32'h80000000, 32'hCAFEF00D, 1'b0},
      '{32'hA5A5A5A5, 32'h1EDC6F41, 7'h06, 32'h01020304, 32'hF0E1D2C3, 32'h55AA55AA, 1'b1},
      '{32'h00000000, 32'h814141AB, 7'h10, 32'hFFFFFFFF, 32'h0000FFFF, 32'h13579BDF, 1'b1},
      '{32'h12345678, 32'h04C11DB7, 7'h20, 32'h89ABCDEF, 32'h76543210, 32'h00000000, 1'b0},
      '{32'hFFFFFFFF, 32'h04C11DB7, 7'h4F, 32'h31323334, 32'h35363738, 32'h39303132, 1'b1}
   };

   function automatic logic [31:0] m_rev(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[31-i] = v[i];
      return r;
   endfunction

   function automatic logic [31:0] m_shape(input logic [31:0] v, input logic [2:0] s);
      logic [31:0] x;
      x = v;
      if (s[0]) for (int k = 0; k < 4; k++) for (int i = 0; i < 8; i++) x[8*k+i] = v[8*k+7-i];
      if (s[1]) x = {x[7:0], x[15:8], x[23:16], x[31:24]};
      if (s[2]) x = {x[15:0], x[31:16]};
      return x;
   endfunction

   function automatic logic [31:0] m_crc(input logic [31:0] c0, input logic [31:0] d,
                                         input logic [31:0] p);
      logic [31:0] c;
      c = c0;
      for (int i = 31; i >= 0; i--) begin
         if (c[31] != d[i]) c = {c[30:0], 1'b0} ^ p;
         else               c = {c[30:0], 1'b0};
      end
      return c;
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      int wd;
      for (wd = 0; wd < 60000 && !finished; wd++) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_mis++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c, pe, pol;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd0, v);  check("R1 ctrl", v, 32'h0);
      rd(4'd1, v);  check("R1 count", v, 32'h0);
      rd(4'd5, v);  check("R1 mask", v, 32'h0);
      rd(4'd9, v);  check("R1 status", v, 32'h00090000);
      rd(4'd10, v); check("R1 result", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // table of vectors: R2 R5 R9 R11 R4 R6
      for (int n = 0; n < 6; n++) begin
         wr(4'd0, 32'h0);
         wr(4'd8, VECS[n].poly);
         idle(10);
         wr(4'd11, VECS[n].seed);
         wr(4'd2, 32'h0);
         wr(4'd3, 32'h0);
         wr(4'd1, 32'd3);
         pe = VECS[n].mir[5] ? m_rev(VECS[n].poly) : VECS[n].poly;
         c = VECS[n].seed;
         c = m_crc(c, m_shape(VECS[n].d0, VECS[n].mir[2:0]), pe);
         c = m_crc(c, m_shape(VECS[n].d1, VECS[n].mir[2:0]), pe);
         c = m_crc(c, m_shape(VECS[n].d2, VECS[n].mir[2:0]), pe);
         v = VECS[n].mir[6] ? m_rev(c) : c;
         wr(4'd3, VECS[n].match ? v : v ^ 32'h1);
         wr(4'd0, RUN | {9'b0, VECS[n].mir, 16'h0});
         wr(4'd4, VECS[n].d0);
         wr(4'd4, VECS[n].d1);
         wr(4'd4, VECS[n].d2);
         idle(4);
         rd(4'd10, v); check($sformatf("R2/R9/R11 vec%0d result", n), v,
                             VECS[n].mir[4] ? m_rev(c) : c);
         rd(4'd1, v);  check($sformatf("R4 vec%0d count", n), v, 32'h0);
         rd(4'd9, v);  check($sformatf("R4/R5 vec%0d flags", n), v & 32'h12,
                             VECS[n].match ? 32'h10 : 32'h12);
         wr(4'd9, 32'h12);
         rd(4'd9, v);  check($sformatf("R6 vec%0d cleared", n), v & 32'h12, 32'h0);
      end

      // R3 polynomial preparation stalls consumption
      pol = 32'h04C11DB7;
      wr(4'd0, 32'h0);
      wr(4'd11, 32'h0);
      wr(4'd2, 32'h0);
      wr(4'd1, 32'd1);
      wr(4'd0, RUN);
      wr(4'd8, pol);
      wr(4'd4, 32'hA1B2C3D4);
      idle(2);
      rd(4'd9, v); check("R3 ready clear", v & 32'h00080000, 32'h0);
      rd(4'd1, v); check("R3 stalled count", v, 32'd1);
      idle(12);
      rd(4'd9, v); check("R3 ready set", v & 32'h00080000, 32'h00080000);
      rd(4'd1, v); check("R3 consumed", v, 32'd0);
      rd(4'd10, v); check("R3 result", v, m_crc(32'h0, 32'hA1B2C3D4, pol));
      wr(4'd9, 32'h12);

      // R8 writes ignored while disabled
      wr(4'd0, 32'h0);
      wr(4'd4, 32'h11111111);
      rd(4'd9, v); check("R8 disabled level", (v >> 20) & 32'h7, 32'd0);

      // R8 queue fills, fifth write dropped
      wr(4'd1, 32'd0);
      wr(4'd11, 32'h0);
      wr(4'd0, RUN);
      for (int k = 0; k < 5; k++) wr(4'd4, 32'h10000001 * (k + 1));
      rd(4'd9, v); check("R8 full level", (v >> 20) & 32'h7, 32'd4);
      check("R8 not ready", v & 32'h00010000, 32'h0);
      wr(4'd1, 32'd5);
      idle(6);
      rd(4'd1, v); check("R8 dropped word", v, 32'd1);
      c = 32'h0;
      for (int k = 0; k < 4; k++) c = m_crc(c, 32'h10000001 * (k + 1), pol);
      rd(4'd10, v); check("R8 four words", v, c);
      rd(4'd9, v); check("R8 ready again", v & 32'h00710000, 32'h00010000);

      // R4 wrong mode holds, reload continues counting
      wr(4'd0, 32'h0);
      wr(4'd1, 32'd1);
      wr(4'd2, 32'd2);
      wr(4'd11, 32'h0);
      wr(4'd0, 32'h11);
      wr(4'd4, 32'h0BADF00D);
      idle(3);
      rd(4'd1, v); check("R4 mode hold", v, 32'd1);
      wr(4'd0, RUN);
      idle(2);
      rd(4'd1, v); check("R4 reload", v, 32'd2);
      rd(4'd9, v); check("R4 expired", v & 32'h10, 32'h10);
      wr(4'd4, 32'h1);
      wr(4'd4, 32'h2);
      idle(3);
      rd(4'd1, v); check("R4 after reload", v, 32'd2);
      c = m_crc(m_crc(m_crc(32'h0, 32'h0BADF00D, pol), 32'h1, pol), 32'h2, pol);
      rd(4'd10, v); check("R4 result", v, c);
      wr(4'd2, 32'h0);
      wr(4'd9, 32'h12);

      // R10 shaping when stored
      wr(4'd0, 32'h0);
      wr(4'd1, 32'd0);
      wr(4'd11, 32'h0);
      wr(4'd0, RUN | 32'h000A0000);
      wr(4'd4, 32'h11223344);
      wr(4'd0, RUN | 32'h00080000);
      wr(4'd1, 32'd1);
      idle(3);
      rd(4'd10, v); check("R10 shaped on write", v, m_crc(32'h0, 32'h44332211, pol));
      // R10 shaping when consumed
      wr(4'd0, 32'h0);
      wr(4'd1, 32'd0);
      wr(4'd11, 32'h0);
      wr(4'd0, RUN | 32'h00020000);
      wr(4'd4, 32'h11223344);
      wr(4'd0, RUN);
      wr(4'd1, 32'd1);
      idle(3);
      rd(4'd10, v); check("R10 shaped on read", v, m_crc(32'h0, 32'h11223344, pol));

      // R7 interrupt masking
      wr(4'd9, 32'h12);
      wr(4'd6, 32'h10);
      rd(4'd5, v); check("R7 mask set", v, 32'h10);
      check("R7 irq idle", {31'b0, irq}, 32'h0);
      wr(4'd1, 32'd1);
      wr(4'd4, 32'h5);
      idle(2);
      check("R7 irq on expiry", {31'b0, irq}, 32'h1);
      wr(4'd7, 32'h10);
      check("R7 irq masked", {31'b0, irq}, 32'h0);
      rd(4'd9, v); check("R7 flag kept", v & 32'h10, 32'h10);
      wr(4'd6, 32'h10);
      check("R7 irq unmasked", {31'b0, irq}, 32'h1);
      wr(4'd9, 32'h00);
      check("R6 zero write keeps", {31'b0, irq}, 32'h1);
      wr(4'd9, 32'h10);
      check("R6 clear drops irq", {31'b0, irq}, 32'h0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule